// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at a root port and absorbs the error messages that arrive from below. Each message carries a two-bit severity code and a 16-bit requester identity. The block keeps seven sticky status flags: received and repeated flags for correctable errors, received and repeated flags for uncorrectable errors, a first-was-fatal flag, and separate non-fatal and fatal received flags. It also keeps two identity fields. Each identity field latches the requester of the first error of its class only. Software clears the flags by writing ones, and it chooses which error classes may interrupt through a three-bit enable register.

The interrupt runs in one of two modes. In legacy mode a level line follows the OR of enable AND received over the three classes. In message mode the block emits a one-cycle pulse with a hardware-supplied vector. It does so only when the enabled-and-received condition goes from false to true, either because a message arrived or because software wrote the enables. The vector number also appears, read-only, in the top bits of the status word.

Top module: `rp_err_collector`

## Requirements
- R1: After synchronous reset, status bits 6:0, both identity fields and the enable register read zero, and neither interrupt output is active.
- R2: A correctable message (severity code 0) sets status bit 0. If bit 0 was already set, it sets bit 1 and leaves identity bits 15:0 unchanged. Otherwise it latches the requester into identity bits 15:0.
- R3: A fatal message (severity code 2) sets status bit 6. It sets status bit 4 only if status bit 2 was clear before the message.
- R4: A non-fatal message (severity code 1) sets status bit 5.
- R5: A fatal or non-fatal message sets status bit 2. If bit 2 was already set, it sets bit 3 and leaves identity bits 31:16 unchanged. Otherwise it latches the requester into identity bits 31:16.
- R6: In message mode, a message produces a pulse one cycle after it arrives. This happens only if the enable for its class is set (enable bit 0 correctable, bit 1 non-fatal, bit 2 fatal) and no class that was already received before the message was enabled. The pulse lasts one cycle and carries the vector input.
- R7: In legacy mode, the level output equals the OR over the three classes of enable AND received (bits 0, 5, 6). No pulse is produced in legacy mode. In message mode the level output stays low.
- R8: In message mode, an enable write produces a pulse only when the enabled-and-received condition was false under the old enables and is true under the new ones.
- R9: Status bits 31:27 always show the vector input, and status bits 26:7 read zero. Neither is writable.
- R10: A clear write clears each of status bits 6:0 written as one. A message in the same cycle wins over the clear for every bit that the message sets, and the message's decisions use the flags as they stood before the clear.
- R11: A message with severity code 3 changes no status bit, no identity field and no interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid_i | input | 1 | An error message is present this cycle |
| msg_sev_i | input | 2 | Severity code: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src_i | input | 16 | Requester identity of the message |
| cmd_we_i | input | 1 | Write strobe for the enable register |
| cmd_wdata_i | input | 3 | New enables: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| clr_we_i | input | 1 | Write-one-to-clear strobe for status |
| clr_mask_i | input | 7 | Status bits 6:0 to clear |
| vec_num_i | input | 5 | Interrupt vector number from hardware |
| mode_msg_i | input | 1 | 1 selects message-pulse mode, 0 selects legacy level mode |
| cmd_o | output | 3 | Current enable register |
| status_o | output | 32 | Status word: flags in 6:0, vector in 31:27 |
| src_id_o | output | 32 | Uncorrectable identity in 31:16, correctable identity in 15:0 |
| irq_level_o | output | 1 | Legacy interrupt level |
| irq_pulse_o | output | 1 | One-cycle message interrupt |
| irq_vec_o | output | 5 | Vector qualified by irq_pulse_o |

## Verification
A flag stuck or set wrongly shows on status_o on the very next cycle after the message or clear that should have moved it. A missed first-error decision goes on to corrupt an identity field and to misjudge the repeat flags of every later message of that class. A wrong received state also shifts the interrupt decision. In message mode that shows up as a missing or extra pulse one cycle after the next message or enable write. In legacy mode it shows up as a wrong level in the same cycle the flags update. The stimulus therefore walks first, repeat, cleared-and-refilled and same-cycle clear cases, and it checks flags, identities and pulse after every step.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;

    localparam int STS_W = 7;
    localparam int CAT_W = 3;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_RSVD     = 2'd3
    } sev_e;

    // Last member is bit 0.
    typedef struct packed {
        logic fatal_rcv;     // 6
        logic nonfatal_rcv;  // 5
        logic first_fatal;   // 4
        logic multi_unc;     // 3
        logic unc_rcv;       // 2
        logic multi_cor;     // 1
        logic cor_rcv;       // 0
    } root_sts_t;

    // Received classes in enable-bit order {fatal, non-fatal, correctable}.
    function automatic logic [CAT_W-1:0] rcv_cats(input root_sts_t s);
        return {s.fatal_rcv, s.nonfatal_rcv, s.cor_rcv};
    endfunction

    function automatic logic [CAT_W-1:0] sev_cat(input sev_e sev);
        logic [CAT_W-1:0] c;
        case (sev)
            SEV_COR:      c = 3'b001;
            SEV_NONFATAL: c = 3'b010;
            SEV_FATAL:    c = 3'b100;
            default:      c = 3'b000;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rp_err_status.sv
module rp_err_status
    import rp_err_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 msg_valid,
    input  sev_e                 msg_sev,
    input  logic [SRC_W-1:0]     msg_src,
    input  logic                 clr_we,
    input  logic [STS_W-1:0]     clr_mask,
    output root_sts_t            sts_q,
    output logic [SRC_W-1:0]     src_cor_q,
    output logic [SRC_W-1:0]     src_unc_q
);

    root_sts_t        sts_d;
    logic [SRC_W-1:0] src_cor_d;
    logic [SRC_W-1:0] src_unc_d;
    logic             is_unc;

    assign is_unc = msg_valid && (msg_sev == SEV_NONFATAL || msg_sev == SEV_FATAL);

    always_comb begin
        sts_d     = sts_q;
        src_cor_d = src_cor_q;
        src_unc_d = src_unc_q;
        if (clr_we) begin
            sts_d = root_sts_t'(sts_q & ~clr_mask);
        end
        // Message updates are applied after the clear, decisions use sts_q.
        if (msg_valid && msg_sev == SEV_COR) begin
            if (sts_q.cor_rcv) sts_d.multi_cor = 1'b1;
            else               src_cor_d       = msg_src;
            sts_d.cor_rcv = 1'b1;
        end
        if (msg_valid && msg_sev == SEV_FATAL) begin
            if (!sts_q.unc_rcv) sts_d.first_fatal = 1'b1;
            sts_d.fatal_rcv = 1'b1;
        end
        if (msg_valid && msg_sev == SEV_NONFATAL) begin
            sts_d.nonfatal_rcv = 1'b1;
        end
        if (is_unc) begin
            if (sts_q.unc_rcv) sts_d.multi_unc = 1'b1;
            else               src_unc_d       = msg_src;
            sts_d.unc_rcv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q     <= '0;
            src_cor_q <= '0;
            src_unc_q <= '0;
        end else begin
            sts_q     <= sts_d;
            src_cor_q <= src_cor_d;
            src_unc_q <= src_unc_d;
        end
    end

    // R2: repeated correctable message marks the repeat flag
    a_r2_multi_cor: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sev == SEV_COR && sts_q.cor_rcv) |=> (sts_q.multi_cor && sts_q.cor_rcv));

    // R3: fatal with no prior uncorrectable marks first-fatal
    a_r3_first_fatal: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sev == SEV_FATAL && !sts_q.unc_rcv) |=> sts_q.first_fatal);

    // R5: later uncorrectable messages keep the first identity
    a_r5_unc_src_hold: assert property (@(posedge clk) disable iff (rst)
        (is_unc && sts_q.unc_rcv) |=> $stable(src_unc_q));

    // R10: a clear with no message empties the written bits
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !msg_valid) |=> (({sts_q} & $past(clr_mask)) == '0));

endmodule

// File: rtl/rp_err_irq.sv
module rp_err_irq
    import rp_err_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_msg,
    input  logic             msg_valid,
    input  sev_e             msg_sev,
    input  logic [CAT_W-1:0] cats,
    input  logic [CAT_W-1:0] cmd_q,
    input  logic             cmd_we,
    input  logic [CAT_W-1:0] cmd_wdata,
    input  logic [VEC_W-1:0] vec_in,
    output logic             irq_level,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    logic was_on;
    logic msg_fire;
    logic cmd_fire;
    logic fire;

    assign was_on    = |(cmd_q & cats);
    assign msg_fire  = msg_valid && |(sev_cat(msg_sev) & cmd_q) && !was_on;
    assign cmd_fire  = cmd_we && |(cmd_wdata & cats) && !was_on;
    assign fire      = mode_msg && (msg_fire || cmd_fire);
    assign irq_level = !mode_msg && was_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= fire;
            if (fire) irq_vector <= vec_in;
        end
    end

    // R6: a pulse follows a message or enable write made in message mode
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ($past(mode_msg) && $past(msg_valid || cmd_we)));

endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
    import rp_err_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int VEC_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 msg_valid_i,
    input  logic [1:0]           msg_sev_i,
    input  logic [SRC_W-1:0]     msg_src_i,
    input  logic                 cmd_we_i,
    input  logic [2:0]           cmd_wdata_i,
    input  logic                 clr_we_i,
    input  logic [6:0]           clr_mask_i,
    input  logic [VEC_W-1:0]     vec_num_i,
    input  logic                 mode_msg_i,
    output logic [2:0]           cmd_o,
    output logic [2*SRC_W-1:0]   status_o,
    output logic [2*SRC_W-1:0]   src_id_o,
    output logic                 irq_level_o,
    output logic                 irq_pulse_o,
    output logic [VEC_W-1:0]     irq_vec_o
);

    localparam int REG_W = 2 * SRC_W;
    localparam int PAD_W = REG_W - VEC_W - STS_W;

    sev_e             sev_w;
    root_sts_t        sts_q;
    logic [SRC_W-1:0] src_cor_q;
    logic [SRC_W-1:0] src_unc_q;
    logic [CAT_W-1:0] cmd_q;

    assign sev_w = sev_e'(msg_sev_i);

    always_ff @(posedge clk) begin
        if (rst)           cmd_q <= '0;
        else if (cmd_we_i) cmd_q <= cmd_wdata_i;
    end

    rp_err_status #(.SRC_W(SRC_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .msg_valid (msg_valid_i),
        .msg_sev   (sev_w),
        .msg_src   (msg_src_i),
        .clr_we    (clr_we_i),
        .clr_mask  (clr_mask_i),
        .sts_q     (sts_q),
        .src_cor_q (src_cor_q),
        .src_unc_q (src_unc_q)
    );

    rp_err_irq #(.VEC_W(VEC_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .mode_msg   (mode_msg_i),
        .msg_valid  (msg_valid_i),
        .msg_sev    (sev_w),
        .cats       (rcv_cats(sts_q)),
        .cmd_q      (cmd_q),
        .cmd_we     (cmd_we_i),
        .cmd_wdata  (cmd_wdata_i),
        .vec_in     (vec_num_i),
        .irq_level  (irq_level_o),
        .irq_pulse  (irq_pulse_o),
        .irq_vector (irq_vec_o)
    );

    assign cmd_o    = cmd_q;
    assign status_o = {vec_num_i, {PAD_W{1'b0}}, sts_q};
    assign src_id_o = {src_unc_q, src_cor_q};

endmodule

// File: tb/rp_err_collector_tb.sv
`timescale 1ns/1ps
module rp_err_collector_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_src = 16'h0;
    logic        cmd_we = 1'b0;
    logic [2:0]  cmd_wdata = 3'd0;
    logic        clr_we = 1'b0;
    logic [6:0]  clr_mask = 7'd0;
    logic [4:0]  vec_num = 5'd9;
    logic        mode_msg = 1'b1;
    logic [2:0]  cmd_o;
    logic [31:0] status_o;
    logic [31:0] src_id_o;
    logic        irq_level_o;
    logic        irq_pulse_o;
    logic [4:0]  irq_vec_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rp_err_collector u_dut (
        .clk(clk), .rst(rst),
        .msg_valid_i(msg_valid), .msg_sev_i(msg_sev), .msg_src_i(msg_src),
        .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .vec_num_i(vec_num), .mode_msg_i(mode_msg),
        .cmd_o(cmd_o), .status_o(status_o), .src_id_o(src_id_o),
        .irq_level_o(irq_level_o), .irq_pulse_o(irq_pulse_o), .irq_vec_o(irq_vec_o)
    );

    // {msg, cmd, clr, sev[2], src[16], data[7], exp_sts[7], exp_src[32], exp_pulse, req[8]}
    localparam int N_ROWS = 13;
    localparam logic [75:0] TAB [N_ROWS] = '{
        {3'b010, 2'd0, 16'h0000, 7'h07, 7'h00, 32'h0000_0000, 1'b0, 8'd8},  // R8 enables, nothing received
        {3'b100, 2'd0, 16'h1111, 7'h00, 7'h01, 32'h0000_1111, 1'b1, 8'd6},  // R6 first correctable fires
        {3'b100, 2'd0, 16'h2222, 7'h00, 7'h03, 32'h0000_1111, 1'b0, 8'd2},  // R2 repeat correctable
        {3'b100, 2'd1, 16'h3333, 7'h00, 7'h27, 32'h3333_1111, 1'b0, 8'd4},  // R4 non-fatal
        {3'b100, 2'd2, 16'h4444, 7'h00, 7'h6F, 32'h3333_1111, 1'b0, 8'd5},  // R5 repeat uncorrectable
        {3'b001, 2'd0, 16'h0000, 7'h7F, 7'h00, 32'h3333_1111, 1'b0, 8'd10}, // R10 clear all
        {3'b100, 2'd2, 16'h5555, 7'h00, 7'h54, 32'h5555_1111, 1'b1, 8'd3},  // R3 first fatal
        {3'b010, 2'd0, 16'h0000, 7'h00, 7'h54, 32'h5555_1111, 1'b0, 8'd8},  // R8 disable all
        {3'b010, 2'd0, 16'h0000, 7'h04, 7'h54, 32'h5555_1111, 1'b1, 8'd8},  // R8 false to true
        {3'b010, 2'd0, 16'h0000, 7'h05, 7'h54, 32'h5555_1111, 1'b0, 8'd8},  // R8 already true
        {3'b100, 2'd3, 16'hAAAA, 7'h00, 7'h54, 32'h5555_1111, 1'b0, 8'd11}, // R11 code 3 ignored
        {3'b101, 2'd0, 16'h6666, 7'h40, 7'h15, 32'h5555_6666, 1'b0, 8'd10}, // R10 clear plus message
        {3'b101, 2'd0, 16'h7777, 7'h01, 7'h17, 32'h5555_6666, 1'b0, 8'd10}  // R10 message beats clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic c, input logic k, input logic [1:0] sev,
                        input logic [15:0] src, input logic [6:0] data);
        @(negedge clk);
        msg_valid = m; msg_sev = sev; msg_src = src;
        cmd_we = c; cmd_wdata = data[2:0];
        clr_we = k; clr_mask = data;
        @(negedge clk);
        msg_valid = 1'b0; cmd_we = 1'b0; clr_we = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {25'd0, status_o[6:0]}, 32'h0);
        chk("R1 ids", src_id_o, 32'h0);
        chk("R1 enables", {29'd0, cmd_o}, 32'h0);
        chk("R1 irq", {30'd0, irq_level_o, irq_pulse_o}, 32'h0);
        // R9 vector field
        chk("R9 vector field", {27'd0, status_o[31:27]}, 32'd9);

        for (int i = 0; i < N_ROWS; i++) begin
            logic [75:0] e;
            string tag;
            e = TAB[i];
            tag = $sformatf("R%0d row%0d", e[7:0], i);
            step(e[75], e[74], e[73], e[72:71], e[70:55], e[54:48]);
            chk({tag, " flags"}, {25'd0, status_o[6:0]}, {25'd0, e[47:41]});
            chk({tag, " ids"}, src_id_o, e[40:9]);
            chk({tag, " pulse"}, {31'd0, irq_pulse_o}, {31'd0, e[8]});
            chk({tag, " level low in message mode"}, {31'd0, irq_level_o}, 32'd0);
            if (e[74]) chk({tag, " enables"}, {29'd0, cmd_o}, {29'd0, e[50:48]});
            if (e[8])  chk({tag, " vector"}, {27'd0, irq_vec_o}, 32'd9);
        end

        // R7 legacy mode: enables 101, flags 0x17
        @(negedge clk); mode_msg = 1'b0;
        @(negedge clk);
        chk("R7 level on", {31'd0, irq_level_o}, 32'd1);
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h0, 7'h7F);
        chk("R7 level after clear", {31'd0, irq_level_o}, 32'd0);
        step(1'b1, 1'b0, 1'b0, 2'd1, 16'h0BBB, 7'h00);
        chk("R7 disabled class", {30'd0, irq_level_o, irq_pulse_o}, 32'd0);
        chk("R5 id after refill", src_id_o, 32'h0BBB_6666);
        step(1'b0, 1'b1, 1'b0, 2'd0, 16'h0, 7'h02);
        chk("R7 enable raises level", {30'd0, irq_level_o, irq_pulse_o}, 32'd2);
        @(negedge clk); mode_msg = 1'b1;
        @(negedge clk);
        chk("R7 level low in message mode", {31'd0, irq_level_o}, 32'd0);

        // R9 vector follows input, pad reads zero
        vec_num = 5'd22;
        @(negedge clk);
        chk("R9 vector field", {27'd0, status_o[31:27]}, 32'd22);
        chk("R9 pad zero", {12'd0, status_o[26:7]}, 32'd0);

        // R6 pulse width and vector
        step(1'b0, 1'b0, 1'b1, 2'd0, 16'h0, 7'h7F);
        step(1'b1, 1'b0, 1'b0, 2'd1, 16'h0CCC, 7'h00);
        chk("R6 pulse", {31'd0, irq_pulse_o}, 32'd1);
        chk("R6 vector", {27'd0, irq_vec_o}, 32'd22);
        @(negedge clk);
        chk("R6 single cycle", {31'd0, irq_pulse_o}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule